// File: doc/BRIEF.md
# Receive Character Queue with Line-Error Tracking

This block buffers received serial characters between the deserializer and the host. Each stored slot holds one 8-bit character and three line-error marks for it: break, framing error and parity error. The deserializer writes a character and its marks on the push side. The pop side is driven by the host's read of the receive holding register.

Beside the data, the block keeps a live count of how many stored characters carry any error mark. From this count it drives a summary error bit, which the interrupt logic uses as the line-status interrupt source. The marks of the character now at the head of the queue are shown as the per-character status bits. The block also flags an overrun, which a line-status read clears, and it reports the fill level. The block does not cover deserialization or interrupt prioritisation.

Reset is asynchronous and active low. Its release passes through a two-stage synchronizer, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `rx_err_fifo`

## Requirements
- R1: While reset is active and after it is released, the queue is empty: `level_o`=0, `empty_o`=1, `full_o`=0, and `err_any_o`, `overrun_o`, `rd_data_o` and the three head marks are all 0.
- R2: The queue holds up to DEPTH=64 characters and returns them in arrival order. `level_o` equals the number of stored characters, and `full_o` is 1 exactly when the level is 64.
- R3: `head_brk_o`, `head_fe_o` and `head_pe_o` (status bits 4, 3 and 2) always show the break, framing and parity marks of the head character. After each pop they show the marks of the new head character.
- R4: When the queue is empty, `rd_data_o` and all three head marks read 0.
- R5: `err_any_o` (status bit 7) is 1 while at least one stored character has any mark set. It returns to 0 only after the last marked character has been popped.
- R6: A push while the queue is full and no pop is requested drops the incoming character and keeps the stored contents. It sets `overrun_o` on the next cycle.
- R7: `lsr_rd_i` clears `overrun_o` and leaves the head marks and `err_any_o` unchanged. If a new overrun occurs in the same cycle as the read, `overrun_o` stays 1.
- R8: A push and a pop in the same cycle both take effect, even when the queue is full. The level stays unchanged, no overrun is raised, and the error count accounts for both characters.
- R9: A pop request while the queue is empty is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| push_i | input | 1 | Write one received character |
| push_data_i | input | 8 | Received character |
| push_brk_i | input | 1 | Break mark of the incoming character |
| push_fe_i | input | 1 | Framing error mark of the incoming character |
| push_pe_i | input | 1 | Parity error mark of the incoming character |
| pop_i | input | 1 | Host read of the receive holding register |
| lsr_rd_i | input | 1 | Host read of the line status register |
| rd_data_o | output | 8 | Head character (0 when empty) |
| head_brk_o | output | 1 | Break mark of head character (status bit 4) |
| head_fe_o | output | 1 | Framing mark of head character (status bit 3) |
| head_pe_o | output | 1 | Parity mark of head character (status bit 2) |
| err_any_o | output | 1 | Some stored character is marked (status bit 7) |
| overrun_o | output | 1 | A character was dropped on a full queue |
| level_o | output | 7 | Number of stored characters |
| empty_o | output | 1 | Queue is empty |
| full_o | output | 1 | Queue holds 64 characters |

## Verification
The hardest situation to reach is a full queue at the moment one of these happens: a pop arrives together with a marked push, or a line-status read arrives together with a dropped push. Either one needs 64 writes with no reads in between, which random traffic with balanced push and pop almost never produces. The stimulus fills the queue on purpose and then drives those cycles directly. A random phase follows with push-heavy and pop-heavy stretches, so the level hits both ends several times while marked characters are spread across the queue.

// File: rtl/rxef_pkg.sv
package rxef_pkg;
  localparam int RXEF_DATA_W = 8;

  typedef struct packed {
    logic                   brk;
    logic                   fe;
    logic                   pe;
    logic [RXEF_DATA_W-1:0] data;
  } rx_entry_t;
endpackage

// File: rtl/rxef_store.sv
module rxef_store
  import rxef_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  rx_entry_t     wr_entry,
  input  logic          rd_en,
  output rx_entry_t     head_entry,
  output logic [LW-1:0] level
);
  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

  rx_entry_t       mem_q [DEPTH];
  logic [AW-1:0]   wr_ptr_q, wr_ptr_d;
  logic [AW-1:0]   rd_ptr_q, rd_ptr_d;
  logic [LW-1:0]   level_q, level_d;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    if (wr_en) wr_ptr_d = wr_ptr_q + AW'(1);
    if (rd_en) rd_ptr_d = rd_ptr_q + AW'(1);
    if (wr_en && !rd_en)      level_d = level_q + LW'(1);
    else if (!wr_en && rd_en) level_d = level_q - LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_ptr_q] <= wr_entry;
  end

  assign head_entry = mem_q[rd_ptr_q];
  assign level      = level_q;

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= DEPTH_L);

  // R9
  no_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q == '0) |-> !rd_en);
endmodule

// File: rtl/rxef_errcnt.sv
module rxef_errcnt #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] count
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && !dec)      cnt_d = cnt_q + CW'(1);
    else if (!inc && dec) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R5
  err_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0) |-> !(dec && !inc));
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rxef_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push_i,
  input  logic [RXEF_DATA_W-1:0] push_data_i,
  input  logic                   push_brk_i,
  input  logic                   push_fe_i,
  input  logic                   push_pe_i,
  input  logic                   pop_i,
  input  logic                   lsr_rd_i,
  output logic [RXEF_DATA_W-1:0] rd_data_o,
  output logic                   head_brk_o,
  output logic                   head_fe_o,
  output logic                   head_pe_o,
  output logic                   err_any_o,
  output logic                   overrun_o,
  output logic [LW-1:0]          level_o,
  output logic                   empty_o,
  output logic                   full_o
);
  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

  logic [1:0]    rst_sync_q;
  logic          rst_s_n;
  rx_entry_t     in_entry, head_entry;
  logic [LW-1:0] level;
  logic [CW-1:0] err_cnt;
  logic          is_empty, is_full, pop_ok, push_ok, drop;
  logic          ovr_q, ovr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  assign in_entry = '{brk: push_brk_i, fe: push_fe_i, pe: push_pe_i, data: push_data_i};
  assign is_empty = (level == '0);
  assign is_full  = (level == DEPTH_L);
  assign pop_ok   = pop_i && !is_empty;
  assign push_ok  = push_i && (!is_full || pop_ok);
  assign drop     = push_i && !push_ok;

  rxef_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .wr_en      (push_ok),
    .wr_entry   (in_entry),
    .rd_en      (pop_ok),
    .head_entry (head_entry),
    .level      (level)
  );

  rxef_errcnt #(.DEPTH(DEPTH)) u_errcnt (
    .clk   (clk),
    .rst_n (rst_s_n),
    .inc   (push_ok && (push_brk_i || push_fe_i || push_pe_i)),
    .dec   (pop_ok && (head_entry.brk || head_entry.fe || head_entry.pe)),
    .count (err_cnt)
  );

  always_comb begin
    ovr_d = ovr_q;
    if (drop)          ovr_d = 1'b1;
    else if (lsr_rd_i) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) ovr_q <= 1'b0;
    else          ovr_q <= ovr_d;
  end

  assign rd_data_o  = is_empty ? '0 : head_entry.data;
  assign head_brk_o = !is_empty && head_entry.brk;
  assign head_fe_o  = !is_empty && head_entry.fe;
  assign head_pe_o  = !is_empty && head_entry.pe;
  assign err_any_o  = (err_cnt != '0);
  assign overrun_o  = ovr_q;
  assign level_o    = level;
  assign empty_o    = is_empty;
  assign full_o     = is_full;

  // R6
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (push_i && full_o && !pop_i) |=> (overrun_o && full_o));

  // R7
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (lsr_rd_i && !(push_i && full_o && !pop_i)) |=> !overrun_o);

  // R8
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (push_i && pop_i && !empty_o) |=> $stable(level_o));

  // R5
  err_fall_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(err_any_o) |-> $past(pop_i));

  // R5
  err_vs_level_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    err_any_o |-> !empty_o);
endmodule

// File: tb/sim_rx_err_fifo.sv
module sim_rx_err_fifo;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       push_i, push_brk_i, push_fe_i, push_pe_i, pop_i, lsr_rd_i;
  logic [7:0] push_data_i;
  logic [7:0] rd_data_o;
  logic       head_brk_o, head_fe_o, head_pe_o, err_any_o, overrun_o, empty_o, full_o;
  logic [6:0] level_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [10:0] mq[$];
  bit          m_ovr;

  always #10 clk = ~clk;

  rx_err_fifo #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
    .push_brk_i(push_brk_i), .push_fe_i(push_fe_i), .push_pe_i(push_pe_i),
    .pop_i(pop_i), .lsr_rd_i(lsr_rd_i), .rd_data_o(rd_data_o),
    .head_brk_o(head_brk_o), .head_fe_o(head_fe_o), .head_pe_o(head_pe_o),
    .err_any_o(err_any_o), .overrun_o(overrun_o), .level_o(level_o),
    .empty_o(empty_o), .full_o(full_o)
  );

  function automatic logic [22:0] expected_vec();
    logic [10:0] h;
    bit e;
    h = (mq.size() > 0) ? mq[0] : 11'd0;
    e = 0;
    foreach (mq[i]) if (mq[i][10:8] != 3'b000) e = 1;
    return {h[7:0], h[10], h[9], h[8], e, m_ovr, 7'(mq.size()),
            (mq.size() == 0), (mq.size() == DEPTH)};
  endfunction

  function automatic logic [22:0] actual_vec();
    return {rd_data_o, head_brk_o, head_fe_o, head_pe_o, err_any_o, overrun_o,
            level_o, empty_o, full_o};
  endfunction

  task automatic check(string req);
    logic [22:0] a, e;
    a = actual_vec();
    e = expected_vec();
    checks++;
    if (a !== e) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  task automatic step(bit ps, logic [7:0] d, logic [2:0] fl, bit pp, bit lr, string req);
    bit pop_ok, push_ok;
    @(negedge clk);
    push_i = ps; push_data_i = d; {push_brk_i, push_fe_i, push_pe_i} = fl;
    pop_i = pp; lsr_rd_i = lr;
    @(posedge clk);
    pop_ok  = pp && (mq.size() > 0);
    push_ok = ps && ((mq.size() < DEPTH) || pop_ok);
    if (pop_ok) void'(mq.pop_front());
    if (push_ok) mq.push_back({fl, d});
    if (ps && !push_ok) m_ovr = 1;
    else if (lr) m_ovr = 0;
    #1;
    check(req);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; push_i = 0; push_data_i = 0; push_brk_i = 0; push_fe_i = 0;
    push_pe_i = 0; pop_i = 0; lsr_rd_i = 0; m_ovr = 0;
    repeat (3) @(negedge clk);
    #1 check("R1");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1 check("R1");

    // R3 R5: flagged middle character, marks follow pops
    step(1, 8'h11, 3'b000, 0, 0, "R2");
    step(1, 8'h22, 3'b001, 0, 0, "R5");
    step(1, 8'h33, 3'b100, 0, 0, "R5");
    step(1, 8'h44, 3'b000, 0, 0, "R2");
    step(0, 0, 0, 1, 0, "R3");
    step(0, 0, 0, 1, 0, "R3");
    step(0, 0, 0, 0, 1, "R7");
    step(0, 0, 0, 1, 0, "R5");
    step(0, 0, 0, 1, 0, "R4");
    step(0, 0, 0, 1, 0, "R9");

    // R6 R7 R8 at full
    for (int i = 0; i < DEPTH; i++)
      step(1, 8'(i + 8'h40), (i == 5) ? 3'b010 : 3'b000, 0, 0, "R2");
    step(1, 8'hEE, 3'b111, 0, 0, "R6");
    step(0, 0, 0, 0, 0, "R6");
    step(1, 8'hEF, 3'b000, 0, 1, "R7");
    step(0, 0, 0, 0, 1, "R7");
    step(1, 8'hA5, 3'b001, 1, 0, "R8");
    step(1, 8'hA6, 3'b000, 1, 0, "R8");
    while (mq.size() > 0) step(0, 0, 0, 1, 0, "R5");
    step(0, 0, 0, 1, 0, "R9");
    step(1, 8'h77, 3'b010, 1, 0, "R9");
    step(0, 0, 0, 1, 0, "R4");

    // random phases: push-heavy then pop-heavy, repeated
    for (int ph = 0; ph < 12; ph++) begin
      for (int k = 0; k < 150; k++) begin
        int pw, pr;
        pw = (ph % 2 == 0) ? 85 : 30;
        pr = (ph % 2 == 0) ? 30 : 85;
        step(($urandom % 100) < pw, 8'($urandom),
             (($urandom % 4) == 0) ? 3'($urandom) : 3'b000,
             ($urandom % 100) < pr, ($urandom % 10) == 0, "R2");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule